// File: doc/BRIEF.md
# Dual-Channel FIFO Read Pipeline

This block is the read half of a memory FIFO. It runs either as one channel with words up to 24 bits wide or as two independent channels of up to 12 bits each. Each channel has a read address pointer that advances by itself, a read data pipeline with a fixed latency of eight enabled clocks, and drive-enable vectors on its 12-bit output port. The drive enables stand in for tristate control. The storage sits outside the block. The block presents an address and a read strobe for each lane, and the array returns that lane's word on `mem_q0` or `mem_q1` in the same cycle.

Each lane holds a small control state machine. State `LS_CLEAR` is entered on reset and means no read has been issued. Transition `first_read` moves it to `LS_FILL` on the first enabled edge, while words are in flight. Transition `pipe_full` moves it to `LS_LIVE` on the enabled edge that brings the first word to the output. From `LS_LIVE` only the transition `reset` leaves, and it returns to `LS_CLEAR`. In single-channel mode, lane 0 carries bits 11..0 and lane 1 carries bits 23..12 of each word, and both lanes follow read enable 0. In dual-channel mode, lane 1 follows its own enable, which is registered for one clock before use.

Top module: `fifo_rd_pipe`

## Requirements
- R1: While `rst_n` is low at a rising edge, both pointers are cleared to 0 and both `q_valid` outputs go low after that edge. Reset is synchronous.
- R2: At a rising edge where `rd_en0_n` is low, `mem_rd0` is high and pointer 0 (`mem_addr0`) advances by one. When `rd_en0_n` is high, the pointer holds.
- R3: The word returned for the read issued at enabled edge k appears on the lane output (`q0` or `q1`) after the 8th later enabled edge of that lane. Edges without enable stall the pipeline, and it holds.
- R4: With `cfg_dual`=1, lane 1 reads and advances pointer 1 at an edge only if `rd_en1_n` was low at the previous rising edge.
- R5: With `cfg_dual`=0, lane 1 reads and advances at the same edges as lane 0, so the word on {`q1`,`q0`} is the combined 24-bit word for that address, with `q1` as the upper half.
- R6: Bit i of `q0_drv` is 1 only when `oe0_n` is low and bit i lies inside the configured width.
- R7: `q1_drv` is all 0 when `oe1_n` is high, and also in single mode when `cfg_width` is 00 or 01.
- R8: The width code is 00=8, 01=12, 10=16, 11=24 bits, and in dual mode it is capped at 12. In single mode, combined bit j (port 1 bit i is j=12+i) is driven only if j < width. In dual mode, port bit i is driven only if i < width. Bits outside the width stay undriven whatever the enables are.
- R9: A pointer at DEPTH-1 wraps to 0 on its next read.
- R10: `q_valid0`/`q_valid1` rise on the enabled edge that brings a lane's first word to its output, and they stay high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Global reset, active low, sampled on the clock |
| cfg_dual | input | 1 | 1 = two independent channels, 0 = single channel |
| cfg_width | input | 2 | Width code 00=8, 01=12, 10=16, 11=24 bits |
| rd_en0_n | input | 1 | Read enable for lane 0 (and single mode), active low |
| rd_en1_n | input | 1 | Read enable for lane 1 in dual mode, active low |
| oe0_n | input | 1 | Output enable for port 0, active low |
| oe1_n | input | 1 | Output enable for port 1, active low |
| mem_q0 | input | 12 | Array data at `mem_addr0` |
| mem_q1 | input | 12 | Array data at `mem_addr1` |
| mem_addr0 | output | AW | Lane 0 read pointer |
| mem_addr1 | output | AW | Lane 1 read pointer |
| mem_rd0 | output | 1 | Lane 0 reads at this edge |
| mem_rd1 | output | 1 | Lane 1 reads at this edge |
| q0 | output | 12 | Port 0 data |
| q1 | output | 12 | Port 1 data |
| q_valid0 | output | 1 | Port 0 carries read data |
| q_valid1 | output | 1 | Port 1 carries read data |
| q0_drv | output | 12 | Per-bit drive enable of port 0 |
| q1_drv | output | 12 | Per-bit drive enable of port 1 |

## Verification
The timing of each result differs. Pointers change on the edge that samples a read. Port data and valid flags change on the 8th later enabled edge of their lane. Lane 1 in dual mode reacts one edge after its enable is seen. The drive enables are combinational and follow the inputs within the same cycle. The bench keeps a behavioural model that counts reads per lane. It updates that model on each rising edge from the inputs sampled at that edge, and compares every output 1 ns after the edge. Inputs change only on falling edges.

// File: rtl/fifo_rd_pkg.sv
package fifo_rd_pkg;

    typedef enum logic [1:0] {
        WD_8  = 2'b00,
        WD_12 = 2'b01,
        WD_16 = 2'b10,
        WD_24 = 2'b11
    } width_e;

    typedef enum logic [1:0] {
        LS_CLEAR = 2'd0,
        LS_FILL  = 2'd1,
        LS_LIVE  = 2'd2
    } lane_state_e;

    function automatic int unsigned width_bits(input logic [1:0] code);
        unique case (width_e'(code))
            WD_8:    return 8;
            WD_12:   return 12;
            WD_16:   return 16;
            default: return 24;
        endcase
    endfunction

endpackage

// File: rtl/fifo_rd_lane.sv
module fifo_rd_lane
    import fifo_rd_pkg::*;
#(
    parameter int W     = 12,
    parameter int DEPTH = 1024,
    parameter int LAT   = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [W-1:0]  mem_q,
    output logic [AW-1:0] ptr,
    output logic [W-1:0]  q,
    output logic          q_valid
);

    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    logic [W-1:0] pipe_d [0:LAT];
    logic [LAT:0] pipe_v;
    lane_state_e  state_q, state_d;

    // pointer and per-stage valid bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr    <= '0;
            pipe_v <= '0;
        end else if (go) begin
            ptr    <= (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
            pipe_v <= {pipe_v[LAT-1:0], 1'b1};
        end
    end

    // data stages: stage 0 captures the array word, the rest shift
    for (genvar s = 0; s <= LAT; s++) begin : g_stage
        if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (go) pipe_d[0] <= mem_q;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (go) pipe_d[s] <= pipe_d[s-1];
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LS_CLEAR;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_CLEAR: if (go)                    state_d = LS_FILL;
            LS_FILL:  if (go && pipe_v[LAT-1])   state_d = LS_LIVE;
            LS_LIVE:                             state_d = LS_LIVE;
            default:                             state_d = LS_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        q       = pipe_d[LAT];
        q_valid = (state_q == LS_LIVE);
    end

endmodule

// File: rtl/fifo_rd_drive.sv
module fifo_rd_drive
    import fifo_rd_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         cfg_dual,
    input  logic [1:0]   cfg_width,
    input  logic         oe0_n,
    input  logic         oe1_n,
    output logic [W-1:0] drv0,
    output logic [W-1:0] drv1
);

    localparam int CW = 2 * W;

    int unsigned        nbits;
    logic [CW-1:0]      used;

    always_comb begin
        nbits = width_bits(cfg_width);
        if (cfg_dual && nbits > W) nbits = W;
    end

    for (genvar j = 0; j < CW; j++) begin : g_used
        assign used[j] = (j < nbits);
    end

    always_comb begin
        if (cfg_dual) begin
            drv0 = used[W-1:0] & {W{~oe0_n}};
            drv1 = used[W-1:0] & {W{~oe1_n}};
        end else begin
            drv0 = used[W-1:0]  & {W{~oe0_n}};
            drv1 = used[CW-1:W] & {W{~oe1_n}};
        end
    end

endmodule

// File: rtl/fifo_rd_pipe.sv
module fifo_rd_pipe
    import fifo_rd_pkg::*;
#(
    parameter int LANE_W = 12,
    parameter int DEPTH  = 1024,
    parameter int LAT    = 8,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_dual,
    input  logic [1:0]        cfg_width,
    input  logic              rd_en0_n,
    input  logic              rd_en1_n,
    input  logic              oe0_n,
    input  logic              oe1_n,
    input  logic [LANE_W-1:0] mem_q0,
    input  logic [LANE_W-1:0] mem_q1,
    output logic [AW-1:0]     mem_addr0,
    output logic [AW-1:0]     mem_addr1,
    output logic              mem_rd0,
    output logic              mem_rd1,
    output logic [LANE_W-1:0] q0,
    output logic [LANE_W-1:0] q1,
    output logic              q_valid0,
    output logic              q_valid1,
    output logic [LANE_W-1:0] q0_drv,
    output logic [LANE_W-1:0] q1_drv
);

    logic en1_seen;

    // lane 1 enable is acted on one edge after it is sampled
    always_ff @(posedge clk) begin
        if (!rst_n) en1_seen <= 1'b0;
        else        en1_seen <= ~rd_en1_n;
    end

    assign mem_rd0 = ~rd_en0_n;
    assign mem_rd1 = cfg_dual ? en1_seen : ~rd_en0_n;

    fifo_rd_lane #(.W(LANE_W), .DEPTH(DEPTH), .LAT(LAT), .AW(AW)) u_lane0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (mem_rd0),
        .mem_q   (mem_q0),
        .ptr     (mem_addr0),
        .q       (q0),
        .q_valid (q_valid0)
    );

    fifo_rd_lane #(.W(LANE_W), .DEPTH(DEPTH), .LAT(LAT), .AW(AW)) u_lane1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (mem_rd1),
        .mem_q   (mem_q1),
        .ptr     (mem_addr1),
        .q       (q1),
        .q_valid (q_valid1)
    );

    fifo_rd_drive #(.W(LANE_W)) u_drive (
        .cfg_dual  (cfg_dual),
        .cfg_width (cfg_width),
        .oe0_n     (oe0_n),
        .oe1_n     (oe1_n),
        .drv0      (q0_drv),
        .drv1      (q1_drv)
    );

endmodule

// File: rtl/fifo_rd_pipe_chk.sv
module fifo_rd_pipe_chk #(
    parameter int LANE_W = 12,
    parameter int DEPTH  = 1024,
    parameter int AW     = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_dual,
    input logic [1:0]        cfg_width,
    input logic              rd_en0_n,
    input logic              rd_en1_n,
    input logic              oe0_n,
    input logic              oe1_n,
    input logic [AW-1:0]     mem_addr0,
    input logic [AW-1:0]     mem_addr1,
    input logic              mem_rd1,
    input logic              q_valid0,
    input logic              q_valid1,
    input logic [LANE_W-1:0] q0_drv,
    input logic [LANE_W-1:0] q1_drv
);

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (mem_addr0 == '0 && mem_addr1 == '0 && !q_valid0 && !q_valid1)); // R1

    AST_PTR0_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en0_n |=> (mem_addr0 == step($past(mem_addr0)))); // R2

    AST_PTR0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en0_n |=> $stable(mem_addr0)); // R2

    AST_DUAL_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dual && !rd_en1_n) |=> (!cfg_dual || mem_rd1)); // R4

    AST_OE0_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        oe0_n |-> (q0_drv == '0)); // R6

    AST_PORT1_NARROW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (oe1_n || (!cfg_dual && !cfg_width[1])) |-> (q1_drv == '0)); // R7

    AST_VALID_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid0 |=> q_valid0)); // R10

endmodule

bind fifo_rd_pipe fifo_rd_pipe_chk #(.LANE_W(LANE_W), .DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_dual  (cfg_dual),
    .cfg_width (cfg_width),
    .rd_en0_n  (rd_en0_n),
    .rd_en1_n  (rd_en1_n),
    .oe0_n     (oe0_n),
    .oe1_n     (oe1_n),
    .mem_addr0 (mem_addr0),
    .mem_addr1 (mem_addr1),
    .mem_rd1   (mem_rd1),
    .q_valid0  (q_valid0),
    .q_valid1  (q_valid1),
    .q0_drv    (q0_drv),
    .q1_drv    (q1_drv)
);

// File: tb/fifo_rd_pipe_bench.sv
`timescale 1ns/1ps
module fifo_rd_pipe_bench;

    localparam int DEPTH = 1024;
    localparam int AW    = $clog2(DEPTH);
    localparam int LAT   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_dual = 1'b0;
    logic [1:0]  cfg_width = 2'b11;
    logic        rd_en0_n = 1'b1;
    logic        rd_en1_n = 1'b1;
    logic        oe0_n = 1'b1;
    logic        oe1_n = 1'b1;
    logic [11:0] mem_q0, mem_q1;
    logic [AW-1:0] mem_addr0, mem_addr1;
    logic        mem_rd0, mem_rd1;
    logic [11:0] q0, q1, q0_drv, q1_drv;
    logic        q_valid0, q_valid1;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    function automatic logic [11:0] word0(input int a);
        return 12'((a * 37 + 5) & 12'hFFF);
    endfunction
    function automatic logic [11:0] word1(input int a);
        return 12'((a * 91 + 2560) & 12'hFFF);
    endfunction

    // behavioural array
    assign mem_q0 = word0(int'(mem_addr0));
    assign mem_q1 = word1(int'(mem_addr1));

    fifo_rd_pipe #(.LANE_W(12), .DEPTH(DEPTH), .LAT(LAT)) u_fifo_rd_pipe (
        .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual), .cfg_width(cfg_width),
        .rd_en0_n(rd_en0_n), .rd_en1_n(rd_en1_n), .oe0_n(oe0_n), .oe1_n(oe1_n),
        .mem_q0(mem_q0), .mem_q1(mem_q1), .mem_addr0(mem_addr0), .mem_addr1(mem_addr1),
        .mem_rd0(mem_rd0), .mem_rd1(mem_rd1), .q0(q0), .q1(q1),
        .q_valid0(q_valid0), .q_valid1(q_valid1), .q0_drv(q0_drv), .q1_drv(q1_drv)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [11:0] exp_drv(input int port, input bit dual,
                                            input logic [1:0] wc, input bit oen);
        int nb;
        logic [11:0] r;
        nb = (wc == 2'b00) ? 8 : (wc == 2'b01) ? 12 : (wc == 2'b10) ? 16 : 24;
        if (dual && nb > 12) nb = 12;
        for (int i = 0; i < 12; i++) begin
            int idx;
            idx = dual ? i : port * 12 + i;
            r[i] = !oen && (idx < nb);
        end
        return r;
    endfunction

    // reference model: read counts per lane
    int  n0 = 0, n1 = 0;
    bit  e1d = 0;
    bit  in_rst = 1;

    always @(posedge clk) begin
        bit go0, go1;
        if (!rst_n) begin
            n0 = 0; n1 = 0; e1d = 0; in_rst = 1;
        end else begin
            in_rst = 0;
            go0 = !rd_en0_n;
            go1 = cfg_dual ? e1d : go0;
            e1d = !rd_en1_n;
            if (go0) n0++;
            if (go1) n1++;
        end
        #1;
        if (!done) begin
            if (in_rst) begin
                check("R1 addr0", int'(mem_addr0), 0);
                check("R1 valid0", int'(q_valid0), 0);
                check("R1 valid1", int'(q_valid1), 0);
            end
            check("R2/R9 addr0", int'(mem_addr0), n0 % DEPTH);
            check(cfg_dual ? "R4 addr1" : "R5 addr1", int'(mem_addr1), n1 % DEPTH);
            check("R10 valid0", int'(q_valid0), int'(n0 > LAT));
            check("R10 valid1", int'(q_valid1), int'(n1 > LAT));
            if (n0 > LAT) check("R3 q0", int'(q0), int'(word0((n0 - LAT - 1) % DEPTH)));
            if (n1 > LAT) check(cfg_dual ? "R4 q1" : "R5 q1", int'(q1),
                                int'(word1((n1 - LAT - 1) % DEPTH)));
            check("R6/R8 q0_drv", int'(q0_drv), int'(exp_drv(0, cfg_dual, cfg_width, oe0_n)));
            check("R7/R8 q1_drv", int'(q1_drv), int'(exp_drv(1, cfg_dual, cfg_width, oe1_n)));
        end
    end

    task automatic do_reset(input bit dual, input logic [1:0] wc);
        @(negedge clk);
        rst_n = 0; cfg_dual = dual; cfg_width = wc; rd_en0_n = 1; rd_en1_n = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic run_random(input int cycles, input int stall_pct);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            rd_en0_n = ($urandom_range(99) < stall_pct);
            rd_en1_n = ($urandom_range(99) < stall_pct);
            oe0_n    = $urandom_range(1);
            oe1_n    = $urandom_range(1);
        end
    endtask

    initial begin
        // R1 reset state, then single 24-bit streaming with stalls (R3, R5)
        do_reset(0, 2'b11);
        run_random(300, 30);
        // R8 every single-mode width, with output enables toggled (R6, R7)
        for (int w = 0; w < 3; w++) begin
            @(negedge clk); cfg_width = 2'(w);
            run_random(60, 20);
        end
        // R4 dual mode, independent enables, widths 12 and 8
        do_reset(1, 2'b01);
        run_random(300, 40);
        @(negedge clk); cfg_width = 2'b00;
        run_random(80, 40);
        // R8 dual mode with an out-of-range width code is capped at 12
        @(negedge clk); cfg_width = 2'b11;
        run_random(40, 40);
        // R9 wrap: continuous reads past DEPTH on both lanes in single mode
        do_reset(0, 2'b10);
        @(negedge clk); oe0_n = 0; oe1_n = 0; rd_en0_n = 0;
        repeat (DEPTH + 40) @(negedge clk);
        // R1 reset in mid-stream clears pointers and valids
        do_reset(1, 2'b01);
        run_random(20, 50);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule